// File: doc/BRIEF.md
# SPI Flash Command Engine with Shared Ring Buffer

This block is a byte-addressed SPI master that runs one serial-flash command per request. Software loads a command byte into a dedicated register, packs the number of bytes to send and to receive into a count register, and queues the outgoing bytes through a data port backed by an eight-entry ring. Writing the start bit drops chip select. The engine then shifts out the command byte and the queued bytes, followed by the requested number of receive bytes. The byte captured during every clock after the command byte is written back into the ring, in the slot it came from.

Sent and received bytes share the one ring, and its contents are never cleared. A software-visible pointer walks the ring, so after a command the response bytes sit directly behind the bytes that were sent. Software collects them by returning the pointer to zero, reading past the sent bytes, and reading on. The serial clock is a selectable division of the system clock.

Top module: `spi_ring_ctrl`

## Requirements
- R1: The register at offset 0x0 holds the command byte and reads back as written. On start it is the first byte shifted out. It is never taken from the ring, and the byte received while it is shifted is discarded.
- R2: The register at offset 0x1 holds the receive byte count in bits 7:4 and the send byte count (command byte excluded) in bits 3:0, each 0 to 8. It reads back exactly as written, before and after a command.
- R3: The ring holds eight bytes and is never cleared. Send bytes are taken from the ring starting at the pointer. Every byte clocked after the command byte, sent or received, has its captured byte stored in the slot at the pointer, and the pointer then advances by one.
- R4: Writing 1 to bit 4 of the control register at offset 0x2 sets the pointer to 0. The bit always reads as 0. The pointer is readable in bits 2:0 of offset 0xD.
- R5: Writing 1 to bit 0 of offset 0x2 while idle starts a command. Bit 0 reads 1 while the command runs and 0 once it has finished.
- R6: Each write or read of the data port at offset 0xC while idle stores or returns the ring byte at the pointer and advances the pointer by one, modulo 8.
- R7: When a command that began with the pointer at 0 finishes, the pointer equals send count plus receive count, modulo 8.
- R8: Bits 5:4 of offset 0xD (reset 0) select the serial clock. Each half period lasts selection+1 system clock cycles, so a 132 MHz system clock gives 66, 33, 22 and 16.5 MHz.
- R9: Serial timing is SPI mode 0, most significant bit first. The clock idles low and chip select stays low from before the first rising edge until after the last one. Output data changes only while the clock falls. Input is sampled on the rising edge. 0x00 is sent during receive bytes, and exactly 8 × (1 + send + receive) rising edges occur.
- R10: While a command runs, every register write (including a second start) is ignored, and reads of the data port do not move the pointer.
- R11: After reset, the registers at 0x0, 0x1, 0x2 and 0xD read 0, chip select is high and the clock is low. Read data is registered, valid the cycle after the read strobe, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench runs commands across all four clock selections. These include a bare command byte, receive-only and send-only commands, and a full eight-send, eight-receive command in which the ring wraps and the received bytes overwrite the sent ones.

A pointer that failed to advance on captured bytes, or that started counting at the command byte, would leave the readback misaligned and the final pointer off by one. A design that reset the ring would lose the sent-slot responses. A wrong divider would show up in the measured high-phase length.

A further command is disturbed while it runs by writes to every register and by data-port reads. A design that honoured these would change the count, the command byte, the speed or the final pointer.

// File: rtl/spi_ring_pkg.sv
package spi_ring_pkg;
  // register offsets
  localparam int OFS_OPC = 0;
  localparam int OFS_CNT = 1;
  localparam int OFS_CTL = 2;
  localparam int OFS_DAT = 12;
  localparam int OFS_STS = 13;
  // control and status bit positions
  localparam int EXEC_BIT = 0;
  localparam int CLR_BIT  = 4;
  localparam int SPD_LSB  = 4;
  localparam int SPD_W    = 2;

  typedef enum logic [1:0] {PH_OPC, PH_TX, PH_RX} phase_t;
endpackage

// File: rtl/spi_ring_clkdiv.sv
module spi_ring_clkdiv #(
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [SELW-1:0] sel,
  output logic            tick
);
  logic [SELW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt_q <= '0;
    else if (cnt_q == sel) cnt_q <= '0;
    else               cnt_q <= cnt_q + SELW'(1);
  end

  // one pulse per half period of the serial clock
  assign tick = run && (cnt_q == sel);
endmodule

// File: rtl/spi_ring_shifter.sv
module spi_ring_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         miso,
  output logic         sck,
  output logic         mosi,
  output logic         byte_done,
  output logic [W-1:0] rx_byte
);
  localparam int BW = $clog2(W);

  logic [W-1:0]  txsh_q, rxsh_q;
  logic [BW-1:0] bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck    <= 1'b0;
      txsh_q <= '0;
      rxsh_q <= '0;
      bit_q  <= '0;
    end else begin
      if (tick) begin
        if (!sck) begin
          sck    <= 1'b1;
          rxsh_q <= {rxsh_q[W-2:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_q != BW'(W-1)) begin
            txsh_q <= {txsh_q[W-2:0], 1'b0};
            bit_q  <= bit_q + BW'(1);
          end
        end
      end
      if (load) begin
        txsh_q <= load_data;
        bit_q  <= '0;
      end
    end
  end

  assign byte_done = tick && sck && (bit_q == BW'(W-1));
  assign mosi      = txsh_q[W-1];
  assign rx_byte   = rxsh_q;
endmodule

// File: rtl/spi_ring_mem.sv
module spi_ring_mem #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [PW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [PW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  // no reset: contents persist across commands
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/spi_ring_ctrl.sv
module spi_ring_ctrl
  import spi_ring_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          spi_cs_n,
  output logic          spi_sck,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = DW / 2;

  logic [DW-1:0]    opc_q, cnt_q;
  logic [SPD_W-1:0] spd_q;
  logic [PW-1:0]    ptr_q;
  logic             busy_q;
  phase_t           ph_q;
  logic [CW-1:0]    txl_q, rxl_q;

  logic hit_opc, hit_cnt, hit_ctl, hit_dat, hit_sts;
  logic wr_ok, start, tick, byte_done, load, more_tx, more_rx, ring_we;
  logic [DW-1:0] rx_byte, load_data, ring_bus, ring_eng, ring_wdata, sts_word;
  logic [PW-1:0] eng_ptr;

  assign hit_opc = bus_addr == AW'(OFS_OPC);
  assign hit_cnt = bus_addr == AW'(OFS_CNT);
  assign hit_ctl = bus_addr == AW'(OFS_CTL);
  assign hit_dat = bus_addr == AW'(OFS_DAT);
  assign hit_sts = bus_addr == AW'(OFS_STS);

  assign wr_ok   = bus_wr && !busy_q;
  assign start   = wr_ok && hit_ctl && bus_wdata[EXEC_BIT];
  assign more_tx = txl_q != '0;
  assign more_rx = rxl_q != '0;
  assign load    = start || (byte_done && (more_tx || more_rx));
  // the next send byte comes from the slot after the one just finished
  assign eng_ptr   = (ph_q == PH_OPC) ? ptr_q : ptr_q + PW'(1);
  assign load_data = start ? opc_q : (more_tx ? ring_eng : '0);
  assign ring_we    = (wr_ok && hit_dat) || (busy_q && byte_done && ph_q != PH_OPC);
  assign ring_wdata = busy_q ? rx_byte : bus_wdata;

  always_comb begin
    sts_word = '0;
    sts_word[SPD_LSB +: SPD_W] = spd_q;
    sts_word[PW-1:0] = ptr_q;
  end

  spi_ring_mem #(.DEPTH(DEPTH), .W(DW)) u_mem (
    .clk(clk), .we(ring_we), .waddr(ptr_q), .wdata(ring_wdata),
    .raddr_a(ptr_q), .rdata_a(ring_bus), .raddr_b(eng_ptr), .rdata_b(ring_eng)
  );

  spi_ring_clkdiv #(.SELW(SPD_W)) u_div (
    .clk(clk), .rst(rst), .run(busy_q), .sel(spd_q), .tick(tick)
  );

  spi_ring_shifter #(.W(DW)) u_shift (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .load_data(load_data),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .byte_done(byte_done),
    .rx_byte(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opc_q    <= '0;
      cnt_q    <= '0;
      spd_q    <= '0;
      ptr_q    <= '0;
      busy_q   <= 1'b0;
      spi_cs_n <= 1'b1;
      ph_q     <= PH_OPC;
      txl_q    <= '0;
      rxl_q    <= '0;
    end else begin
      if (wr_ok) begin
        if (hit_opc) opc_q <= bus_wdata;
        if (hit_cnt) cnt_q <= bus_wdata;
        if (hit_sts) spd_q <= bus_wdata[SPD_LSB +: SPD_W];
        if (hit_dat) ptr_q <= ptr_q + PW'(1);
        if (hit_ctl && bus_wdata[CLR_BIT]) ptr_q <= '0;
        if (start) begin
          busy_q   <= 1'b1;
          spi_cs_n <= 1'b0;
          ph_q     <= PH_OPC;
          txl_q    <= cnt_q[CW-1:0];
          rxl_q    <= cnt_q[DW-1:CW];
        end
      end
      if (bus_rd && !busy_q && hit_dat) ptr_q <= ptr_q + PW'(1);
      if (busy_q && byte_done) begin
        if (ph_q != PH_OPC) ptr_q <= ptr_q + PW'(1);
        if (more_tx) begin
          ph_q  <= PH_TX;
          txl_q <= txl_q - CW'(1);
        end else if (more_rx) begin
          ph_q  <= PH_RX;
          rxl_q <= rxl_q - CW'(1);
        end else begin
          busy_q   <= 1'b0;
          spi_cs_n <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      if      (hit_opc) bus_rdata <= opc_q;
      else if (hit_cnt) bus_rdata <= cnt_q;
      else if (hit_ctl) bus_rdata <= {{(DW-1){1'b0}}, busy_q};
      else if (hit_dat) bus_rdata <= ring_bus;
      else if (hit_sts) bus_rdata <= sts_word;
      else              bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/spi_ring_ctrl_chk.sv
module spi_ring_ctrl_chk #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          cs_n,
  input logic          sck,
  input logic          mosi,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] opc,
  input logic [PW-1:0] ptr
);
  a_r9_clock_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);

  a_r9_data_steady_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> $stable(mosi));

  a_r9_select_before_clock: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> !sck);

  a_r2_count_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cnt));

  a_r1_command_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(opc));

  a_r3_pointer_single_step: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(ptr)) |-> (ptr == PW'($past(ptr) + 1'b1)));
endmodule

bind spi_ring_ctrl spi_ring_ctrl_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy_q), .cs_n(spi_cs_n), .sck(spi_sck),
  .mosi(spi_mosi), .cnt(cnt_q), .opc(opc_q), .ptr(ptr_q)
);

// File: tb/spi_ring_ctrl_bench.sv
`timescale 1ns/1ps
module spi_ring_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic spi_cs_n, spi_sck, spi_mosi, spi_miso;

  always #2 clk = ~clk;

  spi_ring_ctrl u_spi_ring_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int vectors = 0, misses = 0;
  logic [7:0] txb [8];
  logic [7:0] rsp [17];
  logic [7:0] model_ring [8];
  logic mosi_log [4096];
  int rise_cnt = 0, fall_cnt = 0, rise_base = 0, fall_base = 0;
  realtime t_rise = 0, t_fall = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural flash: records MOSI on rising edges, moves MISO on falling edges
  always @(posedge spi_sck) if (!spi_cs_n) begin
    if (rise_cnt == rise_base) t_rise = $realtime;
    mosi_log[rise_cnt % 4096] = spi_mosi;
    rise_cnt++;
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    if (fall_cnt == fall_base) t_fall = $realtime;
    fall_cnt++;
  end
  always_comb begin
    int idx;
    idx = fall_cnt - fall_base;
    spi_miso = (idx >= 0 && idx < 136) ? rsp[idx / 8][7 - (idx % 8)] : 1'b0;
  end

  // every clock: clock must sit low while deselected (R9)
  always @(negedge clk) if (!rst) chk("R9 sck low while deselected", {31'b0, spi_cs_n & spi_sck}, 32'd0);

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic run_cmd(input logic [7:0] op, input int ntx, input int nrx,
                         input logic [1:0] sel, input bit meddle);
    logic [7:0] v, b;
    int n;
    n = ntx + nrx;
    wr(4'hD, {2'b00, sel, 4'h0});
    wr(4'h0, op);
    wr(4'h1, {nrx[3:0], ntx[3:0]});
    wr(4'h2, 8'h10);
    rd(4'h2, v);
    chk("R4 clear bit reads 0", v, 8'h00);
    for (int k = 0; k < ntx; k++) wr(4'hC, txb[k]);
    rd(4'hD, v);
    chk("R6 pointer after queueing", {29'b0, v[2:0]}, ntx % 8);
    wr(4'h2, 8'h10);
    rd(4'hD, v);
    chk("R4 pointer cleared", {29'b0, v[2:0]}, 32'd0);
    rise_base = rise_cnt; fall_base = fall_cnt;
    wr(4'h2, 8'h01);
    rd(4'h2, v);
    chk("R5 busy while running", v, 8'h01);
    if (meddle) begin
      wr(4'h1, 8'h55); wr(4'h0, 8'hAA); wr(4'hD, 8'h30);
      wr(4'hC, 8'h77); wr(4'h2, 8'h11);
      rd(4'hC, v); rd(4'hC, v);
      chk("R10 select held through meddling", {31'b0, spi_cs_n}, 32'd0);
    end
    do rd(4'h2, v); while (v[0]);
    chk("R5 idle after finish", v, 8'h00);
    chk("R9 rising edge count", rise_cnt - rise_base, 8 * (1 + n));
    chk("R8 high phase cycles", int'((t_fall - t_rise) / 4.0), sel + 1);
    for (int j = 0; j <= n; j++) begin
      for (int q = 0; q < 8; q++) b[7 - q] = mosi_log[(rise_base + 8 * j + q) % 4096];
      if (j == 0)        chk("R1 command byte on wire", b, op);
      else if (j <= ntx) chk("R3 send byte from ring", b, txb[j - 1]);
      else               chk("R9 zero during receive", b, 8'h00);
    end
    rd(4'hD, v);
    chk("R7 final pointer", {29'b0, v[2:0]}, n % 8);
    chk("R10 speed unchanged", {30'b0, v[5:4]}, sel);
    rd(4'h1, v);
    chk("R2 count readback", v, {nrx[3:0], ntx[3:0]});
    rd(4'h0, v);
    chk("R1 command readback", v, op);
    for (int k = 0; k < ntx; k++) model_ring[k] = txb[k];
    for (int i = 0; i < n; i++) model_ring[i % 8] = rsp[1 + i];
    wr(4'h2, 8'h10);
    for (int i = 0; i < n; i++) begin
      rd(4'hC, v);
      chk(i < ntx ? "R3 response in sent slot" : "R3 received byte", v, model_ring[i % 8]);
    end
    rd(4'hD, v);
    chk("R6 pointer after reading", {29'b0, v[2:0]}, n % 8);
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 17; i++) rsp[i] = 8'(seed + 37 * i + i * i);
    for (int i = 0; i < 8; i++) txb[i] = 8'(seed * 3 + 11 * i + 5);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R11 reset cs_n high", {31'b0, spi_cs_n}, 32'd1);
    chk("R11 reset sck low", {31'b0, spi_sck}, 32'd0);
    rd(4'h0, v); chk("R11 reset command reg", v, 8'h00);
    rd(4'h1, v); chk("R11 reset count reg", v, 8'h00);
    rd(4'h2, v); chk("R11 reset control reg", v, 8'h00);
    rd(4'hD, v); chk("R11 reset status reg", v, 8'h00);
    wr(4'h0, 8'h3C);
    rd(4'h5, v); chk("R11 unmapped reads 0", v, 8'h00);
    fill(1);  run_cmd(8'h9F, 0, 3, 2'd0, 1'b0);
    fill(2);  run_cmd(8'h03, 3, 4, 2'd1, 1'b0);
    fill(3);  run_cmd(8'h02, 5, 0, 2'd2, 1'b0);
    fill(4);  run_cmd(8'h0B, 8, 8, 2'd3, 1'b0);
    fill(5);  run_cmd(8'h06, 0, 0, 2'd0, 1'b0);
    fill(6);  run_cmd(8'hC5, 2, 3, 2'd3, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    vectors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule